// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This execution unit shifts a 64-bit operand held as packed lanes. The lanes are four 16-bit words, two 32-bit doublewords, or one 64-bit quadword. It performs logical left, logical right and arithmetic right shifts. Every lane is shifted by the same count. The unit decodes a two-byte opcode itself, together with the 3-bit ModRM reg field that the immediate forms use.

The count comes from one of two places. Register and memory forms take it from a full 64-bit second operand. Immediate forms take it from an 8-bit immediate, zero-extended.

Operand fetch and writeback stay outside the unit. The surrounding pipeline presents the opcode bytes, the reg field, the operand, both count sources and a start strobe. It then waits for a one-cycle done pulse, or for the illegal-encoding flag.

Top module: `pshift_unit`

## Requirements
- R1: A logical left shift moves each lane left by the count and fills the vacated low bits with zeroes. No bit crosses into a neighbouring lane.
- R2: A logical right shift moves each lane right by the count and fills the vacated high bits with zeroes.
- R3: An arithmetic right shift fills the vacated high bits of each lane with that lane's own bit 15 (word) or bit 31 (dword).
- R4: When the first opcode byte is 0x0F, these second bytes take the count from `cnt_i`:
  - 0xF1, 0xF2, 0xF3 select left logical on word, dword and qword lanes.
  - 0xE1, 0xE2 select right arithmetic on word and dword lanes.
  - 0xD1, 0xD2, 0xD3 select right logical on word, dword and qword lanes.
- R5: When the first opcode byte is 0x0F, second bytes 0x71, 0x72 and 0x73 select word, dword and qword lanes with the count taken from `imm_i`, zero-extended. The reg field selects the kind: 3'b110 is left logical, 3'b100 is right arithmetic, 3'b010 is right logical.
- R6: The count is compared over all 64 bits. If it is at least the lane width, a logical shift gives an all-zero lane and an arithmetic shift gives a lane filled with its sign bit.
- R7: Take the cycle in which start is accepted as cycle 0. Then `done_o` is high in cycle 3 for the qword right logical shift, and in cycle 2 for every other legal operation. `result_o` holds the new value from that same cycle.
- R8: Any other encoding raises `illegal_o` for exactly cycle 1 and gives no done pulse. This includes a first byte other than 0x0F, and 0x73 with reg field 3'b100. `result_o` keeps its previous value.
- R9: `done_o` lasts one cycle. A start is accepted only while the unit is idle. A start raised while an operation is in flight is dropped: it gives no done and no flag, and the result of the in-flight operation is unaffected.
- R10: After reset, `result_o` is zero and `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| opc0_i | input | 8 | First opcode byte |
| opc1_i | input | 8 | Second opcode byte |
| regf_i | input | 3 | ModRM reg field |
| data_i | input | 64 | Packed operand to shift |
| cnt_i | input | 64 | Count for register and memory forms |
| imm_i | input | 8 | Count for immediate forms |
| result_o | output | 64 | Shifted result, held until the next completion |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle flag for an undefined encoding |

## Verification
The operands mix alternating patterns with negative lanes, so a fill with zeroes can be told apart from a fill with sign bits, and a lane-local shift can be told apart from one whose bits cross a lane edge. Counts are tested on both sides of each boundary:
- width minus one against exactly the width;
- a count with only upper bits set, which shows whether the comparison truncates the count;
- an immediate whose low byte differs from the register count, which shows whether the correct count source was used.

Encodings are tested on both sides of each decode boundary. Illegal neighbours, such as the qword arithmetic form and unlisted reg fields, each pass through the same check on flag, done and result. Latency is measured cycle by cycle, so a qword right logical shift that finishes early, or any other shift that finishes late, is reported.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  typedef enum logic [1:0] {
    SZ_W16 = 2'd0,
    SZ_W32 = 2'd1,
    SZ_W64 = 2'd2
  } lane_sz_e;

  typedef enum logic [1:0] {
    K_SLL = 2'd0,
    K_SRL = 2'd1,
    K_SRA = 2'd2
  } shkind_e;

  typedef struct packed {
    logic     legal;
    logic     use_imm;
    logic     slow;
    lane_sz_e sz;
    shkind_e  kind;
  } dec_t;

endpackage

// File: rtl/pshift_dec.sv
module pshift_dec
  import pshift_pkg::*;
(
  input  logic [7:0] opc0_i,
  input  logic [7:0] opc1_i,
  input  logic [2:0] regf_i,
  output dec_t       dec_o
);

  dec_t d;

  always_comb begin
    d = '{legal: 1'b1, use_imm: 1'b0, slow: 1'b0, sz: SZ_W16, kind: K_SLL};
    unique case (opc1_i)
      8'hF1: begin d.sz = SZ_W16; d.kind = K_SLL; end
      8'hF2: begin d.sz = SZ_W32; d.kind = K_SLL; end
      8'hF3: begin d.sz = SZ_W64; d.kind = K_SLL; end
      8'hE1: begin d.sz = SZ_W16; d.kind = K_SRA; end
      8'hE2: begin d.sz = SZ_W32; d.kind = K_SRA; end
      8'hD1: begin d.sz = SZ_W16; d.kind = K_SRL; end
      8'hD2: begin d.sz = SZ_W32; d.kind = K_SRL; end
      8'hD3: begin d.sz = SZ_W64; d.kind = K_SRL; end
      8'h71, 8'h72, 8'h73: begin
        d.use_imm = 1'b1;
        d.sz = (opc1_i == 8'h71) ? SZ_W16 : (opc1_i == 8'h72) ? SZ_W32 : SZ_W64;
        unique case (regf_i)
          3'b110:  d.kind = K_SLL;
          3'b010:  d.kind = K_SRL;
          3'b100:  d.kind = K_SRA;
          default: d.legal = 1'b0;
        endcase
        if (opc1_i == 8'h73 && regf_i == 3'b100) d.legal = 1'b0;
      end
      default: d.legal = 1'b0;
    endcase
    if (opc0_i != 8'h0F) d.legal = 1'b0;
    d.slow = (d.sz == SZ_W64) && (d.kind == K_SRL);
  end

  assign dec_o = d;

  // R3/R8: a legal decode never asks for a quadword arithmetic shift
  always_comb begin
    if (dec_o.legal === 1'b1)
      a_r8_no_qword_sra: assert (!(dec_o.kind == K_SRA && dec_o.sz == SZ_W64));
  end

endmodule

// File: rtl/pshift_lane.sv
module pshift_lane
  import pshift_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 64
) (
  input  logic [W-1:0]  v_i,
  input  logic [CW-1:0] cnt_i,
  input  shkind_e       kind_i,
  output logic [W-1:0]  y_o
);

  localparam int AW = $clog2(W);

  logic          sat;
  logic [AW-1:0] amt;
  logic          sgn;

  assign sat = |cnt_i[CW-1:AW];
  assign amt = cnt_i[AW-1:0];
  assign sgn = v_i[W-1];

  always_comb begin
    unique case (kind_i)
      K_SLL:   y_o = sat ? '0 : (v_i << amt);
      K_SRL:   y_o = sat ? '0 : (v_i >> amt);
      K_SRA:   y_o = sat ? {W{sgn}} : W'($signed(v_i) >>> amt);
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/pshift_core.sv
module pshift_core
  import pshift_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] cnt_i,
  input  lane_sz_e      sz_i,
  input  shkind_e       kind_i,
  output logic [DW-1:0] y_o
);

  localparam int NSZ = 3;

  logic [DW-1:0] res_sz [NSZ];

  for (genvar gs = 0; gs < NSZ; gs++) begin : g_sz
    localparam int LW = 16 << gs;
    localparam int NL = DW / LW;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      pshift_lane #(.W(LW), .CW(DW)) u_lane (
        .v_i    (data_i[gl*LW +: LW]),
        .cnt_i  (cnt_i),
        .kind_i (kind_i),
        .y_o    (res_sz[gs][gl*LW +: LW])
      );
    end
  end

  always_comb begin
    unique case (sz_i)
      SZ_W16:  y_o = res_sz[0];
      SZ_W32:  y_o = res_sz[1];
      SZ_W64:  y_o = res_sz[2];
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int DW       = 64,
  parameter int IW       = 8,
  parameter int LAT_FAST = 2,
  parameter int LAT_SLOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    opc0_i,
  input  logic [7:0]    opc1_i,
  input  logic [2:0]    regf_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [IW-1:0] imm_i,
  output logic [DW-1:0] result_o,
  output logic          done_o,
  output logic          illegal_o
);

  localparam int RW = $clog2(LAT_SLOW + 1);

  dec_t          dec;
  logic [DW-1:0] cnt_sel;
  logic [DW-1:0] core_y;

  logic          busy_q, busy_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          done_q, done_d;
  logic          ill_q, ill_d;
  logic [DW-1:0] res_q, res_d;
  logic          ld;
  logic [DW-1:0] data_q, cnt_q;
  lane_sz_e      sz_q;
  shkind_e       kind_q;

  pshift_dec u_dec (
    .opc0_i (opc0_i),
    .opc1_i (opc1_i),
    .regf_i (regf_i),
    .dec_o  (dec)
  );

  assign cnt_sel = dec.use_imm ? {{(DW-IW){1'b0}}, imm_i} : cnt_i;

  pshift_core #(.DW(DW)) u_core (
    .data_i (data_q),
    .cnt_i  (cnt_q),
    .sz_i   (sz_q),
    .kind_i (kind_q),
    .y_o    (core_y)
  );

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    res_d  = res_q;
    done_d = 1'b0;
    ill_d  = 1'b0;
    ld     = 1'b0;
    if (start_i && !busy_q) begin
      if (dec.legal) begin
        busy_d = 1'b1;
        rem_d  = dec.slow ? RW'(LAT_SLOW - 1) : RW'(LAT_FAST - 1);
        ld     = 1'b1;
      end else begin
        ill_d = 1'b1;
      end
    end else if (busy_q) begin
      if (rem_q == RW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = core_y;
      end else begin
        rem_d = rem_q - RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      data_q <= data_i;
      cnt_q  <= cnt_sel;
      sz_q   <= dec.sz;
      kind_q <= dec.kind;
    end
  end

  assign result_o  = res_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r8_flag_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(ill_q && done_q));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q));

  a_r7_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

  a_r9_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q != RW'(1)) |=> busy_q);

  a_r9_flag_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> $past(!busy_q && start_i));

endmodule

// File: tb/pshift_unit_tb.sv
`timescale 1ns/1ps
module pshift_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opc0_i, opc1_i;
  logic [2:0]  regf_i;
  logic [63:0] data_i, cnt_i;
  logic [7:0]  imm_i;
  logic [63:0] result_o;
  logic        done_o, illegal_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .opc0_i(opc0_i), .opc1_i(opc1_i), .regf_i(regf_i),
    .data_i(data_i), .cnt_i(cnt_i), .imm_i(imm_i),
    .result_o(result_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  localparam int KLL = 0, KRL = 1, KRA = 2;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int w, input int kind,
                                        input logic [63:0] d, input logic [63:0] c);
    logic [63:0] r;
    int sh;
    r = '0;
    sh = (c >= 64'(w)) ? w : int'(c[6:0]);
    for (int l = 0; l < 64 / w; l++) begin
      for (int b = 0; b < w; b++) begin
        if (kind == KLL)      r[l*w+b] = (b >= sh) ? d[l*w+b-sh] : 1'b0;
        else if (b + sh < w)  r[l*w+b] = d[l*w+b+sh];
        else                  r[l*w+b] = (kind == KRA) ? d[l*w+w-1] : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [7:0] o0, input logic [7:0] o1, input logic [2:0] rf,
                       input logic [63:0] d, input logic [63:0] c, input logic [7:0] im);
    opc0_i = o0; opc1_i = o1; regf_i = rf; data_i = d; cnt_i = c; imm_i = im;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // legal operation: checks latency, result and single done pulse
  task automatic run_op(input string req, input logic [7:0] o1, input logic [2:0] rf,
                        input logic [63:0] d, input logic [63:0] c, input logic [7:0] im,
                        input int w, input int kind, input logic [63:0] ceff, input int lat);
    logic [63:0] exp, got;
    int when, ndone;
    exp = model(w, kind, d, ceff);
    when = 0; ndone = 0; got = '0;
    drive(8'h0F, o1, rf, d, c, im);
    for (int n = 1; n <= 6; n++) begin
      if (done_o) begin
        ndone++;
        if (when == 0) begin when = n; got = result_o; end
      end
      if (illegal_o) check(1'b0, req, "flag on legal op", 64'(illegal_o), 64'd0);
      if (n < 6) @(negedge clk);
    end
    check(when == lat, "R7", $sformatf("latency op %h", o1), 64'(when), 64'(lat));
    check(ndone == 1, "R9", "done pulse count", 64'(ndone), 64'd1);
    check(got === exp, req, $sformatf("result op %h", o1), got, exp);
  endtask

  task automatic run_illegal(input string what, input logic [7:0] o0, input logic [7:0] o1,
                             input logic [2:0] rf);
    logic [63:0] prev;
    int nd;
    prev = result_o; nd = 0;
    drive(o0, o1, rf, 64'h1234_5678_9ABC_DEF0, 64'd1, 8'd1);
    check(illegal_o === 1'b1, "R8", {what, " flag in cycle 1"}, 64'(illegal_o), 64'd1);
    for (int n = 2; n <= 5; n++) begin
      @(negedge clk);
      if (done_o) nd++;
      if (n == 2) check(illegal_o === 1'b0, "R8", {what, " flag drops"}, 64'(illegal_o), 64'd0);
    end
    check(nd == 0, "R8", {what, " no done"}, 64'(nd), 64'd0);
    check(result_o === prev, "R8", {what, " result kept"}, result_o, prev);
  endtask

  task automatic t_reset;
    check(result_o === 64'd0, "R10", "reset result", result_o, 64'd0);
    check(done_o === 1'b0, "R10", "reset done", 64'(done_o), 64'd0);
    check(illegal_o === 1'b0, "R10", "reset flag", 64'(illegal_o), 64'd0);
  endtask

  task automatic t_reg_forms;
    logic [63:0] pat = 64'h8001_7FFE_F00F_0FF0;
    run_op("R1", 8'hF1, 3'd0, pat, 64'd4, 8'd0, 16, KLL, 64'd4, 2);
    run_op("R1", 8'hF2, 3'd0, pat, 64'd9, 8'd0, 32, KLL, 64'd9, 2);
    run_op("R4", 8'hF3, 3'd0, pat, 64'd36, 8'd0, 64, KLL, 64'd36, 2);
    run_op("R2", 8'hD1, 3'd0, pat, 64'd3, 8'd0, 16, KRL, 64'd3, 2);
    run_op("R2", 8'hD2, 3'd0, pat, 64'd17, 8'd0, 32, KRL, 64'd17, 2);
    run_op("R2", 8'hD3, 3'd0, pat, 64'd20, 8'd0, 64, KRL, 64'd20, 3);
    run_op("R3", 8'hE1, 3'd0, pat, 64'd5, 8'd0, 16, KRA, 64'd5, 2);
    run_op("R3", 8'hE2, 3'd0, 64'h8000_0001_7FFF_FFFF, 64'd31, 8'd0, 32, KRA, 64'd31, 2);
  endtask

  task automatic t_imm_forms;
    logic [63:0] pat = 64'hC3A5_5A3C_9F00_00F9;
    run_op("R5", 8'h71, 3'b110, pat, 64'd0, 8'd7, 16, KLL, 64'd7, 2);
    run_op("R5", 8'h71, 3'b100, pat, 64'd0, 8'd2, 16, KRA, 64'd2, 2);
    run_op("R5", 8'h72, 3'b010, pat, 64'd1, 8'd12, 32, KRL, 64'd12, 2);
    run_op("R5", 8'h72, 3'b100, pat, 64'd1, 8'd30, 32, KRA, 64'd30, 2);
    run_op("R5", 8'h73, 3'b110, pat, 64'd2, 8'd63, 64, KLL, 64'd63, 2);
    run_op("R5", 8'h73, 3'b010, pat, 64'd2, 8'd8, 64, KRL, 64'd8, 3);
    run_op("R5", 8'h73, 3'b010, pat, 64'd0, 8'd200, 64, KRL, 64'd200, 3);
  endtask

  task automatic t_big_counts;
    logic [63:0] pat = 64'h8421_7BDE_FFFF_0001;
    run_op("R6", 8'hF1, 3'd0, pat, 64'd15, 8'd0, 16, KLL, 64'd15, 2);
    run_op("R6", 8'hF1, 3'd0, pat, 64'd16, 8'd0, 16, KLL, 64'd16, 2);
    run_op("R6", 8'hE1, 3'd0, pat, 64'd16, 8'd0, 16, KRA, 64'd16, 2);
    run_op("R6", 8'hD2, 3'd0, pat, 64'h1_0000_0000, 8'd0, 32, KRL, 64'h1_0000_0000, 2);
    run_op("R6", 8'hE2, 3'd0, pat, 64'h8000_0000_0000_0000, 8'd0, 32, KRA,
           64'h8000_0000_0000_0000, 2);
    run_op("R6", 8'hD3, 3'd0, pat, 64'd64, 8'd0, 64, KRL, 64'd64, 3);
  endtask

  task automatic t_illegal;
    run_illegal("qword sra imm", 8'h0F, 8'h73, 3'b100);
    run_illegal("bad reg 000", 8'h0F, 8'h71, 3'b000);
    run_illegal("bad reg 111", 8'h0F, 8'h72, 3'b111);
    run_illegal("second byte E3", 8'h0F, 8'hE3, 3'b000);
    run_illegal("first byte 0E", 8'h0E, 8'hF1, 3'b000);
  endtask

  task automatic t_busy;
    logic [63:0] d = 64'hF0F0_1234_8888_0F0F;
    logic [63:0] exp;
    int when, nd;
    exp = model(64, KRL, d, 64'd12);
    when = 0; nd = 0;
    drive(8'h0F, 8'hD3, 3'd0, d, 64'd12, 8'd0);
    // cycle 1: unit busy, offer another legal start and then an illegal one
    opc1_i = 8'hF1; data_i = 64'hFFFF_FFFF_FFFF_FFFF; cnt_i = 64'd1; start_i = 1'b1;
    @(negedge clk);
    opc1_i = 8'h73; regf_i = 3'b100;
    @(negedge clk);
    start_i = 1'b0;
    if (done_o) begin nd++; when = 3; end
    for (int n = 4; n <= 8; n++) begin
      @(negedge clk);
      if (done_o) nd++;
      if (illegal_o) check(1'b0, "R9", "flag from start while busy", 64'(illegal_o), 64'd0);
    end
    check(when == 3, "R9", "in-flight done cycle", 64'(when), 64'd3);
    check(nd == 1, "R9", "starts while busy dropped", 64'(nd), 64'd1);
    check(result_o === exp, "R9", "in-flight result kept", result_o, exp);
  endtask

  initial begin
    #(4ns * 100000);
    failures++; checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    opc0_i = 8'h0F; opc1_i = 8'h00; regf_i = 3'd0;
    data_i = '0; cnt_i = '0; imm_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_forms();
    t_imm_forms();
    t_big_counts();
    t_illegal();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule